// File: doc/BRIEF.md
# Log-Scale Single-Bit Autocorrelator

The block measures the time autocorrelation of the hit streams from one gang of photon-counting pixels as the data arrives. Each time bin delivers one vector with one bit per pixel. For every pixel and every lag the block counts the bins in which that pixel was hit both in the current bin and in the bin one lag earlier. These are the discrete terms of the intensity autocorrelation, and they are formed without storing frames.

The lags are spread logarithmically. Level 0 is a plain register chain that gives lags of 1 to P bins. Each deeper level chains P ring-buffer delay stages of depth P^level. The lags there are k·P^level bins, and each is exact at the base bin resolution. With P = 10 and the bin at 100 ns, four levels give 40 lags from 100 ns to 1 ms.

The pixels share one update path and are swept one per cycle. Each pixel owns a single RAM word that holds the saturating counters for all of its lags. Three further functions sit around this datapath:
- A separate set of per-pixel photon counters is captured at the end of each fixed window of bins.
- A host read port with the lowest priority returns both the lag counters and the window counts.
- A clear input zeroes the counters and the delay history before a run.

Top module: `acf_log_correlator`

## Requirements
- R1: Every accepted bin, the counter of pixel p at lag index l rises by one exactly when bit p of the current vector and bit p of the vector accepted L bins earlier are both 1. Lag index l = level·P + (k−1) maps to L = k·P^level bins, with k from 1 to P.
- R2: Level 0 (lag indices 0 to P−1) correlates each bin with the 1 to P bins just before it.
- R3: Deeper levels give lags that are whole multiples of P^level bins, exact to one bin.
- R4: Bins accepted before the most recent clear or reset never form a coincidence with later bins.
- R5: Reset, or a one-cycle clr pulse, starts a sweep of NPIX cycles that writes zero to every lag counter. The same event zeroes the window counters and snapshots. A bin_valid that arrives during this sweep is ignored.
- R6: A lag counter that reaches all ones (2^ACC_W − 1) stays there and never wraps.
- R7: Host address p·NLAGS + l selects the counter of pixel p, lag index l. rd_valid and rd_data appear in the cycle after a cycle with rd_gnt high.
- R8: rd_gnt stays low while the update sweep reads or writes the counter RAM, and during a clear sweep. A request that is held is granted once the port is free.
- R9: After a bin is accepted, any bin_valid within the next NPIX cycles is ignored and leaves the counters unchanged. Bins must therefore be at least NPIX+1 cycles apart.
- R10: Host address NPIX·NLAGS + p returns how many of the WINDOW_BINS bins in the last completed window had pixel p hit. The value is zero until the first window after a clear completes.
- R11: A host address at or above NPIX·NLAGS + NPIX returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a clear sweep |
| clr | input | 1 | One-cycle pulse that clears the counters and the delay history |
| bin_valid | input | 1 | Marks a new time bin on hit_vec |
| hit_vec | input | NPIX | One hit bit per pixel for the current bin |
| rd_en | input | 1 | Host read request, held until it is granted |
| rd_addr | input | ADDR_W | Host address: lag counters, then window counts |
| rd_gnt | output | 1 | The request is accepted in this cycle |
| rd_valid | output | 1 | rd_data holds the value of the granted read |
| rd_data | output | ACC_W | Read value |

## Verification
The assertions check on every cycle that the read port follows its protocol:
- a grant is followed by valid data one cycle later;
- no grant is given while the counter RAM is being written;
- a clear enters the clear sweep;
- a bin that arrives during a sweep does not disturb the captured vector;
- no update ever lowers a counter field or raises it by more than one.

Only the bench's scenarios can show the rest, because those properties need history across many bins:
- that each lag really spans the right number of bins;
- that history from before a clear is forgotten;
- that saturation happens at the right count;
- that the window snapshots hold the right totals.

// File: rtl/acf_pkg.sv
package acf_pkg;

    localparam int unsigned DEF_NPIX           = 16;
    localparam int unsigned DEF_LAGS_PER_LEVEL = 10;
    localparam int unsigned DEF_LEVELS         = 2;
    localparam int unsigned DEF_ACC_W          = 32;
    localparam int unsigned DEF_WINDOW_BINS    = 10000;

    // Owner of the counter RAM port in a given cycle
    typedef enum logic [1:0] {
        SWEEP_IDLE,
        SWEEP_RUN,
        SWEEP_CLEAR
    } sweep_state_e;

    // What a granted host read returns
    typedef enum logic [1:0] {
        HOST_ACC,
        HOST_CNT,
        HOST_NONE
    } host_kind_e;

    // Integer power, used for the depth of each delay level
    function automatic int unsigned ipow(int unsigned base, int unsigned e);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < e; i++) begin
            r = r * base;
        end
        return r;
    endfunction

endpackage

// File: rtl/acf_delay_level.sv
// One level of the lag structure: STAGES chained delays of DEPTH bins each.
// Tap s carries the vector pushed (s+1)*DEPTH pushes ago, or zero if that
// push predates the last clear.
module acf_delay_level #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 10,
    parameter int unsigned DEPTH  = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  push,
    input  logic [W-1:0]          din,
    output logic [STAGES*W-1:0]   taps
);

    generate
        if (DEPTH == 1) begin : g_chain
            logic [W-1:0] r_q [STAGES];

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    for (int s = 0; s < STAGES; s++) r_q[s] <= '0;
                end else if (push) begin
                    r_q[0] <= din;
                    for (int s = 1; s < STAGES; s++) r_q[s] <= r_q[s-1];
                end
            end

            for (genvar s = 0; s < STAGES; s++) begin : g_tap
                assign taps[s*W +: W] = r_q[s];
            end
        end else begin : g_ring
            localparam int unsigned PTR_W = $clog2(DEPTH);

            logic [W-1:0]     mem [STAGES][DEPTH];
            logic [PTR_W-1:0] ptr_q;
            logic             filled_q;
            logic [W-1:0]     out_w [STAGES];

            for (genvar s = 0; s < STAGES; s++) begin : g_out
                assign out_w[s]       = filled_q ? mem[s][ptr_q] : '0;
                assign taps[s*W +: W] = out_w[s];
            end

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    ptr_q    <= '0;
                    filled_q <= 1'b0;
                end else if (push) begin
                    if (ptr_q == PTR_W'(DEPTH - 1)) begin
                        ptr_q    <= '0;
                        filled_q <= 1'b1;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
            end

            // Storage is never reset; filled_q masks stale contents instead
            always_ff @(posedge clk) begin
                if (push && !(rst || clr)) begin
                    mem[0][ptr_q] <= din;
                    for (int s = 1; s < STAGES; s++) mem[s][ptr_q] <= out_w[s-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/acf_acc_update.sv
// Saturating increment of every lag field of one pixel word.
module acf_acc_update #(
    parameter int unsigned NLAGS = 20,
    parameter int unsigned ACC_W = 32
) (
    input  logic [NLAGS*ACC_W-1:0] old_word,
    input  logic [NLAGS-1:0]       coinc,
    output logic [NLAGS*ACC_W-1:0] new_word
);

    for (genvar l = 0; l < NLAGS; l++) begin : g_lag
        logic [ACC_W-1:0] cur;
        assign cur = old_word[l*ACC_W +: ACC_W];
        assign new_word[l*ACC_W +: ACC_W] =
            (coinc[l] && (cur != '1)) ? cur + 1'b1 : cur;
    end

endmodule

// File: rtl/acf_window_count.sv
// Per-pixel photon totals over fixed windows of WINDOW_BINS accepted bins.
module acf_window_count #(
    parameter int unsigned NPIX        = 16,
    parameter int unsigned WINDOW_BINS = 10000,
    localparam int unsigned CNT_W      = $clog2(WINDOW_BINS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  bin_acc,
    input  logic [NPIX-1:0]       hits,
    output logic [NPIX*CNT_W-1:0] snap
);

    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] run_q  [NPIX];
    logic [CNT_W-1:0] snap_q [NPIX];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bin_q <= '0;
            for (int p = 0; p < NPIX; p++) begin
                run_q[p]  <= '0;
                snap_q[p] <= '0;
            end
        end else if (bin_acc) begin
            if (bin_q == CNT_W'(WINDOW_BINS - 1)) begin
                bin_q <= '0;
                for (int p = 0; p < NPIX; p++) begin
                    snap_q[p] <= run_q[p] + CNT_W'(hits[p]);
                    run_q[p]  <= '0;
                end
            end else begin
                bin_q <= bin_q + 1'b1;
                for (int p = 0; p < NPIX; p++) run_q[p] <= run_q[p] + CNT_W'(hits[p]);
            end
        end
    end

    for (genvar p = 0; p < NPIX; p++) begin : g_snap
        assign snap[p*CNT_W +: CNT_W] = snap_q[p];
    end

endmodule

// File: rtl/acf_log_correlator.sv
module acf_log_correlator
    import acf_pkg::*;
#(
    parameter int unsigned NPIX           = DEF_NPIX,
    parameter int unsigned LAGS_PER_LEVEL = DEF_LAGS_PER_LEVEL,
    parameter int unsigned LEVELS         = DEF_LEVELS,
    parameter int unsigned ACC_W          = DEF_ACC_W,
    parameter int unsigned WINDOW_BINS    = DEF_WINDOW_BINS,
    localparam int unsigned NLAGS         = LAGS_PER_LEVEL * LEVELS,
    localparam int unsigned NACC          = NPIX * NLAGS,
    localparam int unsigned ADDR_W        = $clog2(NACC + NPIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bin_valid,
    input  logic [NPIX-1:0]   hit_vec,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_gnt,
    output logic              rd_valid,
    output logic [ACC_W-1:0]  rd_data
);

    localparam int unsigned PIX_W  = $clog2(NPIX);
    localparam int unsigned LAG_W  = $clog2(NLAGS);
    localparam int unsigned WORD_W = NLAGS * ACC_W;
    localparam int unsigned CNT_W  = $clog2(WINDOW_BINS + 1);

    typedef struct packed {
        host_kind_e       kind;
        logic [PIX_W-1:0] pix;
        logic [LAG_W-1:0] lag;
    } host_req_t;

    sweep_state_e          state_q;
    logic [PIX_W-1:0]      pix_q;
    logic                  bin_acc;
    logic [NPIX-1:0]       cur_q;
    logic [NLAGS*NPIX-1:0] tap_w;
    logic [NLAGS*NPIX-1:0] tap_q;
    logic [NLAGS-1:0]      coinc_w;
    logic                  wr_v_q;
    logic [PIX_W-1:0]      wr_pix_q;
    logic [NLAGS-1:0]      wr_coinc_q;
    logic [WORD_W-1:0]     acc_mem [NPIX];
    logic [WORD_W-1:0]     ram_q;
    logic [WORD_W-1:0]     new_word;
    logic [PIX_W-1:0]      ram_raddr;
    logic                  ram_we;
    logic [PIX_W-1:0]      ram_waddr;
    logic [WORD_W-1:0]     ram_wdata;
    logic [NPIX*CNT_W-1:0] snap_w;
    logic                  port_busy;
    host_req_t             req_w;
    host_req_t             host_q;
    logic                  rd_valid_q;

    assign bin_acc = bin_valid && (state_q == SWEEP_IDLE) && !clr && !rst;

    // ---------------- lag structure: one delay level per generate step
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        acf_delay_level #(
            .W      (NPIX),
            .STAGES (LAGS_PER_LEVEL),
            .DEPTH  (ipow(LAGS_PER_LEVEL, lv))
        ) u_level (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .push (bin_acc),
            .din  (hit_vec),
            .taps (tap_w[lv*LAGS_PER_LEVEL*NPIX +: LAGS_PER_LEVEL*NPIX])
        );
    end

    // Freeze the bin and its delayed copies for the pixel sweep
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur_q <= '0;
            tap_q <= '0;
        end else if (bin_acc) begin
            cur_q <= hit_vec;
            tap_q <= tap_w;
        end
    end

    for (genvar l = 0; l < NLAGS; l++) begin : g_coinc
        assign coinc_w[l] = cur_q[pix_q] & tap_q[l*NPIX + int'(pix_q)];
    end

    // ---------------- sweep control
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= SWEEP_CLEAR;
            pix_q   <= '0;
        end else begin
            unique case (state_q)
                SWEEP_IDLE: begin
                    if (bin_acc) begin
                        state_q <= SWEEP_RUN;
                        pix_q   <= '0;
                    end
                end
                SWEEP_RUN, SWEEP_CLEAR: begin
                    if (pix_q == PIX_W'(NPIX - 1)) begin
                        state_q <= SWEEP_IDLE;
                        pix_q   <= '0;
                    end else begin
                        pix_q <= pix_q + 1'b1;
                    end
                end
                default: state_q <= SWEEP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_v_q     <= 1'b0;
            wr_pix_q   <= '0;
            wr_coinc_q <= '0;
        end else begin
            wr_v_q     <= (state_q == SWEEP_RUN) && !clr;
            wr_pix_q   <= pix_q;
            wr_coinc_q <= coinc_w;
        end
    end

    // ---------------- counter RAM: one word per pixel, all lags side by side
    acf_acc_update #(
        .NLAGS (NLAGS),
        .ACC_W (ACC_W)
    ) u_update (
        .old_word (ram_q),
        .coinc    (wr_coinc_q),
        .new_word (new_word)
    );

    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = wr_pix_q;
        ram_wdata = new_word;
        if (state_q == SWEEP_CLEAR) begin
            ram_we    = 1'b1;
            ram_waddr = pix_q;
            ram_wdata = '0;
        end else if (wr_v_q) begin
            ram_we = 1'b1;
        end
    end

    assign ram_raddr = (state_q == SWEEP_RUN) ? pix_q : req_w.pix;

    always_ff @(posedge clk) begin
        ram_q <= acc_mem[ram_raddr];
        if (ram_we) acc_mem[ram_waddr] <= ram_wdata;
    end

    // ---------------- window photon totals
    acf_window_count #(
        .NPIX        (NPIX),
        .WINDOW_BINS (WINDOW_BINS)
    ) u_window (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .bin_acc (bin_acc),
        .hits    (hit_vec),
        .snap    (snap_w)
    );

    // ---------------- host read port, lowest priority
    always_comb begin
        req_w.kind = HOST_NONE;
        req_w.pix  = '0;
        req_w.lag  = '0;
        if (rd_addr < ADDR_W'(NACC)) begin
            req_w.kind = HOST_ACC;
            req_w.pix  = PIX_W'(rd_addr / NLAGS);
            req_w.lag  = LAG_W'(rd_addr % NLAGS);
        end else if (rd_addr < ADDR_W'(NACC + NPIX)) begin
            req_w.kind = HOST_CNT;
            req_w.pix  = PIX_W'(rd_addr - ADDR_W'(NACC));
        end
    end

    assign port_busy = (state_q != SWEEP_IDLE) || wr_v_q;
    assign rd_gnt    = rd_en && !port_busy && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q  <= 1'b0;
            host_q.kind <= HOST_NONE;
            host_q.pix  <= '0;
            host_q.lag  <= '0;
        end else begin
            rd_valid_q <= rd_gnt;
            if (rd_gnt) host_q <= req_w;
        end
    end

    assign rd_valid = rd_valid_q;

    always_comb begin
        unique case (host_q.kind)
            HOST_ACC: rd_data = ram_q[int'(host_q.lag)*ACC_W +: ACC_W];
            HOST_CNT: rd_data = ACC_W'(snap_w[int'(host_q.pix)*CNT_W +: CNT_W]);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/acf_log_correlator_chk.sv
module acf_log_correlator_chk
    import acf_pkg::*;
#(
    parameter int unsigned NPIX  = 16,
    parameter int unsigned NLAGS = 20,
    parameter int unsigned ACC_W = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   clr,
    input logic                   bin_valid,
    input logic                   rd_gnt,
    input logic                   rd_valid,
    input sweep_state_e           state_q,
    input logic                   ram_we,
    input logic                   wr_v_q,
    input logic [NPIX-1:0]        cur_q,
    input logic [NLAGS*ACC_W-1:0] ram_q,
    input logic [NLAGS*ACC_W-1:0] ram_wdata
);

    AST_VALID_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
        rd_gnt |=> rd_valid); // R7

    AST_VALID_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_gnt)); // R7

    AST_NO_GNT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> !rd_gnt); // R8

    AST_CLEAR_STARTS_SWEEP: assert property (@(posedge clk) disable iff (rst)
        clr |=> (state_q == SWEEP_CLEAR)); // R5

    AST_BIN_DROPPED_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (bin_valid && (state_q == SWEEP_RUN) && !clr) |=> $stable(cur_q)); // R9

    for (genvar l = 0; l < NLAGS; l++) begin : g_lag
        AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            (wr_v_q && (state_q != SWEEP_CLEAR)) |->
            (ram_wdata[l*ACC_W +: ACC_W] >= ram_q[l*ACC_W +: ACC_W])); // R6

        AST_ACC_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
            (wr_v_q && (state_q != SWEEP_CLEAR)) |->
            ((ram_wdata[l*ACC_W +: ACC_W] - ram_q[l*ACC_W +: ACC_W]) <= ACC_W'(1))); // R1
    end

endmodule

bind acf_log_correlator acf_log_correlator_chk #(
    .NPIX  (NPIX),
    .NLAGS (NLAGS),
    .ACC_W (ACC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .bin_valid (bin_valid),
    .rd_gnt    (rd_gnt),
    .rd_valid  (rd_valid),
    .state_q   (state_q),
    .ram_we    (ram_we),
    .wr_v_q    (wr_v_q),
    .cur_q     (cur_q),
    .ram_q     (ram_q),
    .ram_wdata (ram_wdata)
);

// File: tb/acf_log_correlator_test.sv
module acf_log_correlator_test;

    localparam int NPIX   = 8;
    localparam int LPL    = 3;
    localparam int LEV    = 3;
    localparam int ACC_W  = 6;
    localparam int WB     = 20;
    localparam int NLAGS  = LPL * LEV;
    localparam int NACC   = NPIX * NLAGS;
    localparam int ADDR_W = $clog2(NACC + NPIX);
    localparam int MAXACC = (1 << ACC_W) - 1;

    logic              clk = 1'b0;
    logic              rst, clr, bin_valid, rd_en;
    logic [NPIX-1:0]   hit_vec;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_gnt, rd_valid;
    logic [ACC_W-1:0]  rd_data;

    always #4 clk = ~clk;

    acf_log_correlator #(
        .NPIX           (NPIX),
        .LAGS_PER_LEVEL (LPL),
        .LEVELS         (LEV),
        .ACC_W          (ACC_W),
        .WINDOW_BINS    (WB)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .bin_valid (bin_valid),
        .hit_vec   (hit_vec),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_gnt    (rd_gnt),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // ---------------- reference model
    logic [NPIX-1:0] hist [$];
    int exp_acc [NPIX][NLAGS];
    int win_run [NPIX];
    int win_snap[NPIX];
    int win_bins;

    function automatic int lag_of(int l);
        int b = 1;
        for (int i = 0; i < l / LPL; i++) b = b * LPL;
        return (l % LPL + 1) * b;
    endfunction

    task automatic model_clear();
        hist.delete();
        win_bins = 0;
        for (int p = 0; p < NPIX; p++) begin
            win_run[p]  = 0;
            win_snap[p] = 0;
            for (int l = 0; l < NLAGS; l++) exp_acc[p][l] = 0;
        end
    endtask

    task automatic model_bin(input logic [NPIX-1:0] v);
        int n = hist.size();
        for (int p = 0; p < NPIX; p++) begin
            for (int l = 0; l < NLAGS; l++) begin
                int lb = lag_of(l);
                if (n >= lb && v[p] && hist[n-lb][p] && exp_acc[p][l] < MAXACC)
                    exp_acc[p][l]++;
            end
            if (v[p]) win_run[p]++;
        end
        hist.push_back(v);
        win_bins++;
        if (win_bins == WB) begin
            win_bins = 0;
            for (int p = 0; p < NPIX; p++) begin
                win_snap[p] = win_run[p];
                win_run[p]  = 0;
            end
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- stimulus tasks
    task automatic send_bin(input logic [NPIX-1:0] v);
        @(negedge clk);
        bin_valid = 1'b1;
        hit_vec   = v;
        @(negedge clk);
        bin_valid = 1'b0;
        model_bin(v);
        repeat (NPIX) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        repeat (NPIX + 1) @(negedge clk);
    endtask

    task automatic host_read(input int addr, output int data);
        int waited = 0;
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = ADDR_W'(addr);
        #1;
        while (!rd_gnt && waited < 200) begin
            @(negedge clk);
            #1;
            waited++;
        end
        @(negedge clk);
        rd_en = 1'b0;
        data  = rd_valid ? int'(rd_data) : -1;
    endtask

    task automatic check_all(input string req);
        int d;
        for (int p = 0; p < NPIX; p++) begin
            for (int l = 0; l < NLAGS; l++) begin
                host_read(p * NLAGS + l, d);
                chk(req, d, exp_acc[p][l]);
            end
        end
    endtask

    task automatic check_counts(input string req);
        int d;
        for (int p = 0; p < NPIX; p++) begin
            host_read(NACC + p, d);
            chk(req, d, win_snap[p]);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // ---------------- watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- scenarios
    initial begin
        int d;
        int unsigned seed;
        seed      = $urandom(32'd4711);
        rst       = 1'b1;
        clr       = 1'b0;
        bin_valid = 1'b0;
        rd_en     = 1'b0;
        rd_addr   = '0;
        hit_vec   = '0;
        model_clear();
        repeat (4) @(negedge clk);
        chk("R7 rd_valid low in reset", int'(rd_valid), 0);
        rst = 1'b0;
        rd_en = 1'b1;
        #1;
        chk("R8 no grant during post-reset clear", int'(rd_gnt), 0);
        rd_en = 1'b0;
        repeat (NPIX + 2) @(negedge clk);
        check_all("R5 reset zeroes counters");
        check_counts("R10 counts zero after reset");

        // R2: short lags on pixel 5
        send_bin(8'h20); send_bin(8'h00); send_bin(8'h20); send_bin(8'h20);
        send_bin(8'h00); send_bin(8'h20);
        check_all("R2 level-0 lags");

        // R3: one pair of hits 18 bins apart on pixel 3
        do_clear();
        send_bin(8'h08);
        for (int i = 0; i < 17; i++) send_bin(8'h00);
        send_bin(8'h08);
        host_read(3 * NLAGS + 7, d);
        chk("R3 lag 18 bins", d, 1);
        host_read(3 * NLAGS + 8, d);
        chk("R3 lag 27 bins untouched", d, 0);
        check_all("R3 deep lags");

        // R4/R5: history before clear and a bin during the clear sweep are dropped
        send_bin(8'hFF);
        send_bin(8'hFF);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        bin_valid = 1'b1;
        hit_vec   = 8'hFF;
        @(negedge clk);
        bin_valid = 1'b0;
        model_clear();
        repeat (NPIX + 1) @(negedge clk);
        check_all("R5 clear zeroes counters");
        send_bin(8'hFF);
        check_all("R4 no coincidence across clear");

        // R9: a second bin inside the sweep is ignored
        do_clear();
        send_bin(8'h0F);
        @(negedge clk);
        bin_valid = 1'b1;
        hit_vec   = 8'hF0;
        @(negedge clk);
        bin_valid = 1'b0;
        model_bin(8'hF0);
        repeat (NPIX) @(negedge clk);
        @(negedge clk);
        bin_valid = 1'b1;
        hit_vec   = 8'hFF;
        @(negedge clk);
        bin_valid = 1'b0;
        repeat (3) @(negedge clk);
        bin_valid = 1'b1;
        hit_vec   = 8'h00;
        @(negedge clk);
        bin_valid = 1'b0;
        model_bin(8'hFF);
        repeat (NPIX) @(negedge clk);
        check_all("R9 busy bin ignored");

        // R8: read held while the update sweep owns the RAM
        @(negedge clk);
        bin_valid = 1'b1;
        hit_vec   = 8'hFF;
        @(negedge clk);
        bin_valid = 1'b0;
        model_bin(8'hFF);
        rd_en   = 1'b1;
        rd_addr = ADDR_W'((NPIX - 1) * NLAGS);
        #1;
        chk("R8 grant withheld during sweep", int'(rd_gnt), 0);
        rd_en = 1'b0;
        host_read((NPIX - 1) * NLAGS, d);
        chk("R8 held read returns updated value", d, exp_acc[NPIX-1][0]);

        // R6: saturation
        do_clear();
        for (int i = 0; i < 70; i++) send_bin(8'hFF);
        host_read(0, d);
        chk("R6 lag-1 counter saturated", d, MAXACC);
        check_all("R6 saturation");

        // R1/R10: constrained random traffic
        do_clear();
        for (int i = 0; i < 150; i++) begin
            logic [NPIX-1:0] v;
            for (int p = 0; p < NPIX; p++) v[p] = ($urandom % 100) < 35;
            send_bin(v);
            repeat ($urandom % 3) @(negedge clk);
        end
        check_all("R1 random coincidences");
        check_counts("R10 window counts");

        // R11: out-of-range address
        host_read(NACC + NPIX + 5, d);
        chk("R11 unmapped address", d, 0);
        host_read((1 << ADDR_W) - 1, d);
        chk("R11 top address", d, 0);

        // R7: valid exactly one cycle after grant
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = ADDR_W'(NACC);
        #1;
        chk("R7 grant when idle", int'(rd_gnt), 1);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R7 valid after grant", int'(rd_valid), 1);
        chk("R7 count data", int'(rd_data), win_snap[0]);
        @(negedge clk);
        chk("R7 valid drops", int'(rd_valid), 0);

        if (seed == 32'hFFFF_FFFF) $display("seed wrapped");
        finish_run();
    end

endmodule